// File: doc/BRIEF.md
# Firmware Image Loader

This block takes a firmware image that is already held in a word-addressed, read-only buffer and moves its payload into a processing engine's instruction memory and data memory. It reads the buffer through a synchronous port with one cycle of latency. It checks the three-word header, then walks the table of block entries that opens the payload. Each code block is checked against the payload bounds and against the target memory size before its words are written out through a write port. Each write carries an address, a data word and a command byte.

A load begins with a one-cycle `start` pulse. It ends with a one-cycle `done` pulse, or with a one-cycle `error` pulse that carries a 3-bit reason code. After an error the block makes no more reads and no more writes. Blocks that passed their checks before the failing one stay written. The memory sizes depend on a small-memory or large-memory variant and on the engine number. Both are fixed by parameters. The block refuses to load while the engine reports that it is running.

Top module: `fw_image_loader`

## Requirements
- R1: The first header word is accepted when it equals 0xFEEDF00D, or when it equals the same value with its four bytes reversed. In the reversed case, every later word read from the buffer is byte-reversed before it is used, so both forms load identical memory contents.
- R2: Any other first word ends the load with error code 0 (bad magic).
- R3: Header word 2 is the payload length in words. If `img_len` differs from that length plus 3, the load ends with code 1.
- R4: The load ends with code 2 when bits 27:24 of header word 1 differ from the configured engine number. It also ends with code 2 in the small-memory variant when bits 31:28 of that word are non-zero.
- R5: The payload opens with two-word entries. The first word of an entry is the type and the second is the offset. A type of 0xF ends the table. If no type word equal to 0xF sits at an even payload index below the payload length, the load ends with code 3. A table with no entries before the end marker completes with `done` and writes nothing.
- R6: Let N be the number of entries. An entry offset that is below 2N+1, or whose value plus 2 exceeds the payload length, gives code 4. Code 4 is also given when a block's offset plus 2 plus its word count exceeds the payload length.
- R7: An entry type other than 0 (instruction) or 1 (data) gives code 6.
- R8: A block is rejected with code 5 when its start address plus its word count exceeds the target memory size. A block that ends exactly at the limit is accepted. The sizes in words are as follows. In the small variant, data memory holds 0x800, and instruction memory holds 0x1000 for engine 0 and 0x800 for the other engines. In the large variant, both memories hold 0x1000.
- R9: A code block is laid out as a start address, a word count, and then the data words. Each data word is written to consecutive addresses starting at the start address, on consecutive cycles. The command byte is 0x11 for instruction blocks and 0x13 for data blocks. Blocks are written in table order.
- R10: When `start` arrives while `engine_running` is high, the block makes no buffer read. It raises `error` with code 7 in the cycle that follows.
- R11: `done` and `error` are never high together. Each stays high for exactly one cycle, after which the block is idle again. Both are low after reset.
- R12: From the cycle `error` is raised, no further memory write occurs. Writes of blocks that were accepted earlier in the same load stay in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a load |
| engine_running | input | 1 | The target engine is executing; loading is refused |
| img_len | input | AW+1 | Total image length in words |
| img_rd_en | output | 1 | Buffer read request |
| img_rd_addr | output | AW | Buffer word address |
| img_rd_data | input | 32 | Buffer data, valid one cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | MEM_AW | Target memory word address |
| mem_wr_data | output | 32 | Word to write |
| mem_wr_cmd | output | 8 | 0x11 instruction write, 0x13 data write |
| done | output | 1 | One-cycle pulse: load completed |
| error | output | 1 | One-cycle pulse: load aborted |
| err_code | output | 3 | Reason code, valid while `error` is high |

## Verification
The busy refusal is the only result tied to a fixed cycle. The error pulse must appear at the first sampling point after the clock edge that captured `start`, with no buffer read in between, and the bench checks that exact cycle. Every other result depends on the image contents. The bench therefore samples at each falling edge: any write strobe seen is compared at once with the head of the queue that the behavioural model built from the requirements. The final `done` or `error` is accepted in whatever cycle it appears, within a fixed bound. In the cycle after the pulse, both `done` and `error` must be low.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
   localparam logic [31:0] FWL_MAGIC     = 32'hFEED_F00D;
   localparam logic [31:0] FWL_MAGIC_REV = 32'h0DF0_EDFE;
   localparam logic [31:0] FWL_T_INSTR   = 32'h0000_0000;
   localparam logic [31:0] FWL_T_DATA    = 32'h0000_0001;
   localparam logic [31:0] FWL_T_END     = 32'h0000_000F;
   localparam logic [7:0]  FWL_CMD_INSTR = 8'h11;
   localparam logic [7:0]  FWL_CMD_DATA  = 8'h13;

   typedef enum logic [2:0] {
      E_MAGIC  = 3'd0,
      E_SIZE   = 3'd1,
      E_ID     = 3'd2,
      E_NOEND  = 3'd3,
      E_OFFSET = 3'd4,
      E_TOOBIG = 3'd5,
      E_TYPE   = 3'd6,
      E_BUSY   = 3'd7
   } fwl_err_e;

   typedef enum logic [3:0] {
      S_IDLE, S_MAGIC, S_IDW, S_SIZE, S_SCAN, S_ETYPE, S_EOFF,
      S_BADDR, S_BCNT, S_COPY, S_DONE, S_FAIL
   } fwl_state_e;
endpackage

// File: rtl/fwl_swap.sv
module fwl_swap #(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   input  logic         en,
   output logic [W-1:0] dout
);
   localparam int NB = W / 8;
   logic [W-1:0] rev;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rev[8*b +: 8] = din[W-8*(b+1) +: 8];
   end

   assign dout = en ? rev : din;
endmodule

// File: rtl/fwl_mem_limits.sv
module fwl_mem_limits #(
   parameter bit SMALL_MEM = 1'b1,
   parameter int ENGINE_ID = 0
) (
   output logic [31:0] instr_lim,
   output logic [31:0] data_lim,
   output logic        dev_must_zero
);
   if (SMALL_MEM) begin : g_small
      assign data_lim      = 32'h0000_0800;
      assign instr_lim     = (ENGINE_ID == 0) ? 32'h0000_1000 : 32'h0000_0800;
      assign dev_must_zero = 1'b1;
   end else begin : g_large
      assign data_lim      = 32'h0000_1000;
      assign instr_lim     = 32'h0000_1000;
      assign dev_must_zero = 1'b0;
   end
endmodule

// File: rtl/fwl_block_check.sv
module fwl_block_check #(
   parameter int LEN_W = 13
) (
   input  logic [31:0]      type_w,
   input  logic [31:0]      off_w,
   input  logic [LEN_W-1:0] size,
   input  logic [LEN_W-1:0] tab_end,
   input  logic [31:0]      baddr,
   input  logic [31:0]      cnt,
   input  logic [31:0]      instr_lim,
   input  logic [31:0]      data_lim,
   output logic             off_bad,
   output logic             type_bad,
   output logic             too_big,
   output logic             no_fit,
   output logic             is_data
);
   import fwl_pkg::*;
   localparam int XW = 34;

   logic [XW-1:0] off_x, size_x, end_x, addr_x, cnt_x, lim_x;

   assign is_data  = (type_w == FWL_T_DATA);
   assign type_bad = !((type_w == FWL_T_INSTR) || is_data);
   assign off_x    = XW'(off_w);
   assign size_x   = XW'(size);
   assign end_x    = XW'(tab_end);
   assign addr_x   = XW'(baddr);
   assign cnt_x    = XW'(cnt);
   assign lim_x    = XW'(is_data ? data_lim : instr_lim);

   assign off_bad  = (off_x + XW'(2) > size_x) || (off_x < end_x);
   assign too_big  = (addr_x + cnt_x) > lim_x;
   assign no_fit   = (off_x + XW'(2) + cnt_x) > size_x;
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader #(
   parameter int  AW        = 12,
   parameter int  MEM_AW    = 13,
   parameter int  ENGINE_ID = 0,
   parameter bit  SMALL_MEM = 1'b1,
   localparam int LEN_W     = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              engine_running,
   input  logic [LEN_W-1:0]  img_len,
   output logic              img_rd_en,
   output logic [AW-1:0]     img_rd_addr,
   input  logic [31:0]       img_rd_data,
   output logic              mem_wr_en,
   output logic [MEM_AW-1:0] mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic [7:0]        mem_wr_cmd,
   output logic              done,
   output logic              error,
   output logic [2:0]        err_code
);
   import fwl_pkg::*;

   localparam int CW = LEN_W + 2;

   if (ENGINE_ID < 0 || ENGINE_ID > 15) begin : g_bad_engine
      $error("ENGINE_ID must fit in four bits");
   end
   if (AW < 4 || AW > 28) begin : g_bad_aw
      $error("AW out of supported range");
   end
   if (MEM_AW < 13 || MEM_AW > 32) begin : g_bad_mem_aw
      $error("MEM_AW must address 0x1000 words");
   end

   fwl_state_e       state_q, state_d;
   fwl_err_e         err_q, err_d;
   logic             swap_q, swap_d;
   logic [3:0]       eng_q, eng_d, dev_q, dev_d;
   logic [LEN_W-1:0] size_q, size_d, k_q, k_d, nblk_q, nblk_d;
   logic [LEN_W-1:0] idx_q, idx_d, te_q, te_d, off_q, off_d;
   logic [LEN_W-1:0] cnt_q, cnt_d, j_q, j_d;
   logic [31:0]      type_q, type_d, baddr_q, baddr_d;

   logic [31:0] rd_word, chk_off, instr_lim, data_lim;
   logic        dev_must_zero, off_bad, type_bad, too_big, no_fit, is_data;
   logic        id_bad, last_blk, idle_w;

   fwl_swap #(.W(32)) u_swap (
      .din(img_rd_data), .en(swap_q), .dout(rd_word)
   );

   fwl_mem_limits #(.SMALL_MEM(SMALL_MEM), .ENGINE_ID(ENGINE_ID)) u_lim (
      .instr_lim(instr_lim), .data_lim(data_lim), .dev_must_zero(dev_must_zero)
   );

   assign chk_off = (state_q == S_EOFF) ? rd_word : 32'(off_q);

   fwl_block_check #(.LEN_W(LEN_W)) u_chk (
      .type_w(type_q), .off_w(chk_off), .size(size_q), .tab_end(te_q),
      .baddr(baddr_q), .cnt(rd_word), .instr_lim(instr_lim),
      .data_lim(data_lim), .off_bad(off_bad), .type_bad(type_bad),
      .too_big(too_big), .no_fit(no_fit), .is_data(is_data)
   );

   assign id_bad   = (eng_q != 4'(ENGINE_ID)) || (dev_must_zero && (dev_q != 4'd0));
   assign last_blk = (idx_q + LEN_W'(1)) == nblk_q;
   assign idle_w   = (state_q == S_IDLE);

   always_comb begin
      state_d = state_q;  err_d  = err_q;   swap_d = swap_q;
      eng_d   = eng_q;    dev_d  = dev_q;   size_d = size_q;
      k_d     = k_q;      nblk_d = nblk_q;  idx_d  = idx_q;
      te_d    = te_q;     off_d  = off_q;   cnt_d  = cnt_q;
      j_d     = j_q;      type_d = type_q;  baddr_d = baddr_q;
      img_rd_en   = 1'b0;
      img_rd_addr = '0;
      mem_wr_en   = 1'b0;
      mem_wr_addr = MEM_AW'(baddr_q + 32'(j_q));
      mem_wr_data = rd_word;
      mem_wr_cmd  = is_data ? FWL_CMD_DATA : FWL_CMD_INSTR;

      unique case (state_q)
         S_IDLE: begin
            if (start) begin
               if (engine_running) begin
                  err_d   = E_BUSY;
                  state_d = S_FAIL;
               end else begin
                  img_rd_en = 1'b1;
                  state_d   = S_MAGIC;
               end
            end
         end
         S_MAGIC: begin
            if (img_rd_data == FWL_MAGIC || img_rd_data == FWL_MAGIC_REV) begin
               swap_d      = (img_rd_data == FWL_MAGIC_REV);
               img_rd_en   = 1'b1;
               img_rd_addr = AW'(1);
               state_d     = S_IDW;
            end else begin
               err_d   = E_MAGIC;
               state_d = S_FAIL;
            end
         end
         S_IDW: begin
            eng_d       = rd_word[27:24];
            dev_d       = rd_word[31:28];
            img_rd_en   = 1'b1;
            img_rd_addr = AW'(2);
            state_d     = S_SIZE;
         end
         S_SIZE: begin
            size_d = rd_word[LEN_W-1:0];
            if ({2'b00, rd_word} + 34'd3 != 34'(img_len)) begin
               err_d   = E_SIZE;
               state_d = S_FAIL;
            end else if (id_bad) begin
               err_d   = E_ID;
               state_d = S_FAIL;
            end else if (rd_word == 32'd0) begin
               err_d   = E_NOEND;
               state_d = S_FAIL;
            end else begin
               k_d         = '0;
               img_rd_en   = 1'b1;
               img_rd_addr = AW'(3);
               state_d     = S_SCAN;
            end
         end
         S_SCAN: begin
            if (rd_word == FWL_T_END) begin
               nblk_d = k_q;
               te_d   = LEN_W'({k_q, 1'b0} + (LEN_W+1)'(1));
               if (k_q == '0) begin
                  state_d = S_DONE;
               end else begin
                  idx_d       = '0;
                  img_rd_en   = 1'b1;
                  img_rd_addr = AW'(3);
                  state_d     = S_ETYPE;
               end
            end else if (CW'({k_q, 1'b0}) + CW'(2) >= CW'(size_q)) begin
               err_d   = E_NOEND;
               state_d = S_FAIL;
            end else begin
               k_d         = k_q + LEN_W'(1);
               img_rd_en   = 1'b1;
               img_rd_addr = AW'(CW'({k_q, 1'b0}) + CW'(5));
            end
         end
         S_ETYPE: begin
            type_d      = rd_word;
            img_rd_en   = 1'b1;
            img_rd_addr = AW'(CW'({idx_q, 1'b0}) + CW'(4));
            state_d     = S_EOFF;
         end
         S_EOFF: begin
            if (off_bad) begin
               err_d   = E_OFFSET;
               state_d = S_FAIL;
            end else begin
               off_d       = rd_word[LEN_W-1:0];
               img_rd_en   = 1'b1;
               img_rd_addr = AW'(CW'(rd_word[LEN_W-1:0]) + CW'(3));
               state_d     = S_BADDR;
            end
         end
         S_BADDR: begin
            baddr_d     = rd_word;
            img_rd_en   = 1'b1;
            img_rd_addr = AW'(CW'(off_q) + CW'(4));
            state_d     = S_BCNT;
         end
         S_BCNT: begin
            if (type_bad) begin
               err_d   = E_TYPE;
               state_d = S_FAIL;
            end else if (too_big) begin
               err_d   = E_TOOBIG;
               state_d = S_FAIL;
            end else if (no_fit) begin
               err_d   = E_OFFSET;
               state_d = S_FAIL;
            end else if (rd_word == 32'd0) begin
               if (last_blk) begin
                  state_d = S_DONE;
               end else begin
                  idx_d       = idx_q + LEN_W'(1);
                  img_rd_en   = 1'b1;
                  img_rd_addr = AW'(CW'({idx_q, 1'b0}) + CW'(5));
                  state_d     = S_ETYPE;
               end
            end else begin
               cnt_d       = rd_word[LEN_W-1:0];
               j_d         = '0;
               img_rd_en   = 1'b1;
               img_rd_addr = AW'(CW'(off_q) + CW'(5));
               state_d     = S_COPY;
            end
         end
         S_COPY: begin
            mem_wr_en = 1'b1;
            j_d       = j_q + LEN_W'(1);
            if (j_q + LEN_W'(1) == cnt_q) begin
               if (last_blk) begin
                  state_d = S_DONE;
               end else begin
                  idx_d       = idx_q + LEN_W'(1);
                  img_rd_en   = 1'b1;
                  img_rd_addr = AW'(CW'({idx_q, 1'b0}) + CW'(5));
                  state_d     = S_ETYPE;
               end
            end else begin
               img_rd_en   = 1'b1;
               img_rd_addr = AW'(CW'(off_q) + CW'(j_q) + CW'(6));
            end
         end
         S_DONE:  state_d = S_IDLE;
         S_FAIL:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;  err_q  <= E_MAGIC;  swap_q <= 1'b0;
         eng_q   <= '0;      dev_q  <= '0;       size_q <= '0;
         k_q     <= '0;      nblk_q <= '0;       idx_q  <= '0;
         te_q    <= '0;      off_q  <= '0;       cnt_q  <= '0;
         j_q     <= '0;      type_q <= '0;       baddr_q <= '0;
      end else begin
         state_q <= state_d; err_q  <= err_d;    swap_q <= swap_d;
         eng_q   <= eng_d;   dev_q  <= dev_d;    size_q <= size_d;
         k_q     <= k_d;     nblk_q <= nblk_d;   idx_q  <= idx_d;
         te_q    <= te_d;    off_q  <= off_d;    cnt_q  <= cnt_d;
         j_q     <= j_d;     type_q <= type_d;   baddr_q <= baddr_d;
      end
   end

   assign done     = (state_q == S_DONE);
   assign error    = (state_q == S_FAIL);
   assign err_code = err_q;
endmodule

// File: rtl/fwl_loader_chk.sv
module fwl_loader_chk #(
   parameter int MEM_AW = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle,
   input logic              start,
   input logic              engine_running,
   input logic              img_rd_en,
   input logic              mem_wr_en,
   input logic [MEM_AW-1:0] mem_wr_addr,
   input logic [7:0]        mem_wr_cmd,
   input logic              done,
   input logic              error,
   input logic [2:0]        err_code
);
   a_r10_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start && engine_running) |=> (error && err_code == 3'd7));

   a_r10_busy_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start && engine_running) |-> !img_rd_en);

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error);

   a_r11_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |=> idle);

   a_r12_quiet_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (!mem_wr_en && !img_rd_en));

   a_r9_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wr_cmd == 8'h11 || mem_wr_cmd == 8'h13));

   a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && $past(mem_wr_en)) |->
         (mem_wr_addr == MEM_AW'($past(mem_wr_addr) + MEM_AW'(1)) &&
          $stable(mem_wr_cmd)));
endmodule

bind fw_image_loader fwl_loader_chk #(.MEM_AW(MEM_AW)) u_loader_chk (
   .clk(clk), .rst_n(rst_n), .idle(idle_w), .start(start),
   .engine_running(engine_running), .img_rd_en(img_rd_en),
   .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_cmd(mem_wr_cmd),
   .done(done), .error(error), .err_code(err_code)
);

// File: tb/test_fw_image_loader.sv
`timescale 1ns/1ps
module test_fw_image_loader;
   localparam int AW  = 12;
   localparam int LW  = AW + 1;
   localparam int MAW = 13;
   localparam logic [31:0] MAGIC = 32'hFEED_F00D;

   logic           clk = 1'b0, rst_n = 1'b0, start = 1'b0, engine_running = 1'b0;
   logic [LW-1:0]  img_len = '0;
   logic           img_rd_en, mem_wr_en, done, error;
   logic [AW-1:0]  img_rd_addr;
   logic [31:0]    img_rd_data = '0, mem_wr_data;
   logic [MAW-1:0] mem_wr_addr;
   logic [7:0]     mem_wr_cmd;
   logic [2:0]     err_code;

   int tests = 0, fails = 0;
   logic [31:0] img [0:1023];
   logic [31:0] pay [0:255];
   logic [71:0] exp_q [$];
   bit m_sw;

   always #2.5 clk = ~clk;

   fw_image_loader #(.AW(AW), .MEM_AW(MAW), .ENGINE_ID(0), .SMALL_MEM(1'b1)) i_fw_image_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .engine_running(engine_running),
      .img_len(img_len), .img_rd_en(img_rd_en), .img_rd_addr(img_rd_addr),
      .img_rd_data(img_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .mem_wr_cmd(mem_wr_cmd), .done(done),
      .error(error), .err_code(err_code)
   );

   always @(posedge clk) if (img_rd_en) img_rd_data <= img[img_rd_addr[9:0]];

   function automatic logic [31:0] swab(logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   function automatic logic [31:0] rw(int i);
      return m_sw ? swab(img[i]) : img[i];
   endfunction

   // Behavioural model of the requirements: returns the error code or -1 for done,
   // and queues the expected writes as {cmd, addr, data}.
   function automatic int model();
      longint size, te, off, a, c, lim;
      logic [31:0] id, t;
      int k;
      if (engine_running) return 7;
      if (img[0] == MAGIC) m_sw = 1'b0;
      else if (img[0] == swab(MAGIC)) m_sw = 1'b1;
      else return 0;
      size = rw(2);
      if (longint'(img_len) != size + 3) return 1;
      id = rw(1);
      if (id[27:24] != 4'd0 || id[31:28] != 4'd0) return 2;
      k = 0;
      while (2*k < size && rw(3 + 2*k) != 32'hF) k++;
      if (2*k >= size) return 3;
      te = 2*k + 1;
      for (int i = 0; i < k; i++) begin
         t = rw(3 + 2*i);
         off = rw(4 + 2*i);
         if (off + 2 > size || off < te) return 4;
         a = rw(3 + int'(off));
         c = rw(4 + int'(off));
         if (t == 0) lim = 4096;
         else if (t == 1) lim = 2048;
         else return 6;
         if (a + c > lim) return 5;
         if (off + 2 + c > size) return 4;
         for (int j = 0; j < c; j++)
            exp_q.push_back({(t == 1) ? 8'h13 : 8'h11, 32'(a + j), rw(5 + int'(off) + j)});
      end
      return -1;
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
      end
   endtask

   task automatic std_pay();
      pay[0] = 32'h0;  pay[1] = 32'd5;  pay[2] = 32'h1;  pay[3] = 32'd10; pay[4] = 32'hF;
      pay[5] = 32'hFFD; pay[6] = 32'd3;
      pay[7] = 32'hA1B2_C3D4; pay[8] = 32'h1122_3344; pay[9] = 32'hDEAD_0009;
      pay[10] = 32'h7FE; pay[11] = 32'd2;
      pay[12] = 32'hC0DE_0012; pay[13] = 32'h5A5A_0013;
   endtask

   task automatic build(bit sw, logic [31:0] id, int psize, int adj);
      img[0] = sw ? swab(MAGIC) : MAGIC;
      img[1] = id;
      img[2] = psize;
      for (int i = 0; i < psize; i++) img[3+i] = pay[i];
      if (sw) for (int i = 1; i < 3 + psize; i++) img[i] = swab(img[i]);
      img_len = LW'(3 + psize + adj);
   endtask

   task automatic run_case(string tag, bit busy_case);
      int expv, cyc;
      bit seen, rd_seen;
      logic [71:0] e;
      exp_q.delete();
      expv = model();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 0; seen = 1'b0; rd_seen = 1'b0;
      while (!seen && cyc < 20000) begin
         if (img_rd_en) rd_seen = 1'b1;
         if (mem_wr_en) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R12", {tag, " unexpected write addr"}, mem_wr_addr, 0);
            end else begin
               e = exp_q.pop_front();
               chk(mem_wr_addr == e[32 +: MAW] && mem_wr_data == e[31:0],
                   "R9", {tag, " write addr/data"}, {mem_wr_addr, mem_wr_data},
                   {e[32 +: MAW], e[31:0]});
               chk(mem_wr_cmd == e[71:64], "R9", {tag, " write cmd"}, mem_wr_cmd, e[71:64]);
            end
         end
         if (done || error) seen = 1'b1;
         else begin
            @(negedge clk);
            cyc++;
         end
      end
      if (expv < 0)
         chk(done && !error, tag, "completion (done)", {done, error}, 2'b10);
      else
         chk(error && !done && err_code == 3'(expv), tag, "error code",
             {error, done, err_code}, {2'b10, 3'(expv)});
      chk(exp_q.size() == 0, tag, "missing writes", exp_q.size(), 0);
      if (busy_case) begin
         chk(cyc == 0, "R10", "busy error cycle", cyc, 0);
         chk(!rd_seen, "R10", "busy read made", rd_seen, 0);
      end
      @(negedge clk);
      chk(!done && !error, "R11", {tag, " pulse length"}, {done, error}, 0);
   endtask

   initial begin
      #(200000 * 5.0);
      fails++; tests++;
      $display("FAIL R11 watchdog expired: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) img[i] = '0;
      for (int i = 0; i < 256; i++) pay[i] = '0;
      repeat (3) @(negedge clk);
      chk(!done && !error && !mem_wr_en && !img_rd_en, "R11", "reset state",
          {done, error, mem_wr_en, img_rd_en}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 / R8 / R9: plain image, instr block ends at 0x1000, data block at 0x800
      std_pay(); build(1'b0, 32'h0012_3456, 14, 0); run_case("R1 plain", 1'b0);
      // R1: byte-reversed image, same expected contents
      std_pay(); build(1'b1, 32'h0012_3456, 14, 0); run_case("R1 swapped", 1'b0);
      // R2: bad magic
      std_pay(); build(1'b0, 32'h0, 14, 0); img[0] = 32'hFEED_F00E; run_case("R2", 1'b0);
      // R3: length mismatch
      std_pay(); build(1'b0, 32'h0, 14, 1); run_case("R3", 1'b0);
      // R4: engine field and device field
      std_pay(); build(1'b0, 32'h0100_0000, 14, 0); run_case("R4 engine", 1'b0);
      std_pay(); build(1'b1, 32'h1000_0000, 14, 0); run_case("R4 device", 1'b0);
      // R5: no end marker, then empty table
      std_pay(); pay[4] = 32'h1; build(1'b0, 32'h0, 14, 0); run_case("R5 no end", 1'b0);
      pay[0] = 32'hF; build(1'b0, 32'h0, 1, 0); run_case("R5 empty", 1'b0);
      // R6: offset inside table, offset past payload, block beyond payload
      std_pay(); pay[1] = 32'd4; build(1'b0, 32'h0, 14, 0); run_case("R6 low", 1'b0);
      std_pay(); pay[3] = 32'd13; build(1'b0, 32'h0, 14, 0); run_case("R6 high", 1'b0);
      std_pay(); pay[10] = 32'h0; pay[11] = 32'd3; build(1'b0, 32'h0, 14, 0); run_case("R6 fit", 1'b0);
      // R8: instruction and data overflow by one word; R12 first block remains
      std_pay(); pay[5] = 32'hFFE; build(1'b0, 32'h0, 14, 0); run_case("R8 instr", 1'b0);
      std_pay(); pay[10] = 32'h7FF; build(1'b0, 32'h0, 14, 0); run_case("R8 data R12", 1'b0);
      // R7 / R12: bad second type after a good block
      std_pay(); pay[2] = 32'h2; build(1'b1, 32'h0, 14, 0); run_case("R7 R12", 1'b0);
      // R10: busy engine
      std_pay(); build(1'b0, 32'h0, 14, 0); engine_running = 1'b1;
      run_case("R10", 1'b1);
      engine_running = 1'b0;
      // back-to-back recovery after a refusal
      std_pay(); build(1'b0, 32'h0, 14, 0); run_case("R1 after busy", 1'b0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule